// File: doc/BRIEF.md
# Flash Program Command Controller

This block sits between a register interface and a flash array. Software writes a single command word that carries a protection key, a target page number and an operation code. The controller checks the key, the code, the page range and the lock state of the lock region that holds the page. It then runs an optional erase phase and a program phase against a timed array model. When the last phase ends it can also set or clear that region's lock bit.

A status byte reports a ready flag and two separate sticky error flags. One flag covers malformed or mistimed commands. The other covers attempts to program inside a locked region. Reading the status byte clears both error flags. A one-bit mode setting enables a completion interrupt. The interrupt stays asserted until the status byte is read or a new command is accepted.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: The command word is laid out as key in bits [31:24], page number in bits [23:8] and operation code in bits [7:0]. A word whose key differs from the KEY parameter sets the command-error flag (status bit 1) and starts no operation, so ready stays 1.
- R2: A code outside {0x01 write, 0x02 write+lock, 0x03 erase+write, 0x04 erase+write+lock, 0x08 set-lock, 0x09 clear-lock}, or a page number >= NUM_PAGES, sets the command-error flag and starts no operation.
- R3: An accepted command clears ready (status bit 0) from the next cycle. A program command stays busy for PROG_CYCLES+1 cycles (plus ERASE_CYCLES for erase variants). A lock command stays busy for 1 cycle. Ready then returns to 1.
- R4: The erase variants (0x03, 0x04) assert arr_erase for exactly ERASE_CYCLES cycles, and arr_prog follows immediately. The other program codes never assert arr_erase. arr_erase and arr_prog are never high together.
- R5: The lock variants (0x02, 0x04) set the lock bit of the page's region after programming ends.
- R6: A program code aimed at a page in a locked region sets the lock-error flag (status bit 2), asserts neither arr_erase nor arr_prog, and leaves ready at 1.
- R7: Code 0x08 sets and code 0x09 clears the lock bit of the page's region. Each lock bit covers the PAGES_PER_REGION consecutive pages region = page / PAGES_PER_REGION.
- R8: A command written while ready is 0 is ignored and sets the command-error flag. The running operation completes unchanged.
- R9: stat_rdata shows the current flags. The cycle after a stat_re strobe, both error flags read 0 unless a new error is reported in that same cycle.
- R10: When mode_rdy_ie is set, irq rises once an accepted command completes and stays high until a status read or a new accepted command. irq is never high while the enable is 0.
- R11: After reset, ready is 1, both error flags and irq are 0, the array strobes are idle and all regions are unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Command word: key, page, code |
| mode_we | input | 1 | Mode register write strobe |
| mode_rdy_ie | input | 1 | Ready interrupt enable value to write |
| stat_re | input | 1 | Status read strobe; clears error flags |
| stat_rdata | output | 8 | Status: bit0 ready, bit1 command error, bit2 lock error |
| irq | output | 1 | Completion interrupt |
| arr_erase | output | 1 | Array model erase phase active |
| arr_prog | output | 1 | Array model program phase active |
| arr_page | output | 16 | Page of the running operation |

## Verification
The bench builds the block with NUM_PAGES=32, PAGES_PER_REGION=4, ERASE_CYCLES=5 and PROG_CYCLES=7. With eight small regions, random page numbers often land in the same region. This exercises lock, reject and unlock sequences and region boundaries within a few hundred commands. The short phase counts keep each operation to at most 13 busy cycles, so the exact length of every phase can be measured for every command. Page numbers are drawn slightly past NUM_PAGES so that the out-of-range page path is also hit.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int WORD_W = 32;
  localparam int KEY_W  = 8;
  localparam int PAGE_W = 16;
  localparam int CODE_W = 8;
  localparam int KEY_LSB  = PAGE_W + CODE_W;
  localparam int PAGE_LSB = CODE_W;
  localparam int STAT_W = 8;
  localparam int ST_RDY  = 0;
  localparam int ST_CERR = 1;
  localparam int ST_LERR = 2;

  localparam logic [CODE_W-1:0] OP_WR       = 8'h01;
  localparam logic [CODE_W-1:0] OP_WR_LK    = 8'h02;
  localparam logic [CODE_W-1:0] OP_ER_WR    = 8'h03;
  localparam logic [CODE_W-1:0] OP_ER_WR_LK = 8'h04;
  localparam logic [CODE_W-1:0] OP_LOCK     = 8'h08;
  localparam logic [CODE_W-1:0] OP_UNLOCK   = 8'h09;

  typedef struct packed {
    logic valid;
    logic erase;
    logic prog;
    logic lock_after;
    logic set_lock;
    logic clr_lock;
  } op_t;

  typedef enum logic [1:0] {PH_IDLE, PH_ERASE, PH_PROG, PH_DONE} phase_t;

  function automatic op_t decode_op(input logic [CODE_W-1:0] code);
    op_t o;
    o = '0;
    unique case (code)
      OP_WR:       begin o.valid = 1'b1; o.prog = 1'b1; end
      OP_WR_LK:    begin o.valid = 1'b1; o.prog = 1'b1; o.lock_after = 1'b1; end
      OP_ER_WR:    begin o.valid = 1'b1; o.prog = 1'b1; o.erase = 1'b1; end
      OP_ER_WR_LK: begin o.valid = 1'b1; o.prog = 1'b1; o.erase = 1'b1;
                         o.lock_after = 1'b1; end
      OP_LOCK:     begin o.valid = 1'b1; o.set_lock = 1'b1; end
      OP_UNLOCK:   begin o.valid = 1'b1; o.clr_lock = 1'b1; end
      default:     o = '0;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
#(
  parameter logic [7:0] KEY              = 8'h5A,
  parameter int         NUM_PAGES        = 64,
  parameter int         PAGES_PER_REGION = 8,
  parameter int         REGION_W         = 3
) (
  input  logic [WORD_W-1:0] word,
  output logic              key_ok,
  output op_t               op,
  output logic              page_ok,
  output logic [PAGE_W-1:0] page,
  output logic [REGION_W-1:0] region
);

  localparam logic [PAGE_W-1:0] NP_LIM = PAGE_W'(NUM_PAGES);
  localparam logic [PAGE_W-1:0] PPR    = PAGE_W'(PAGES_PER_REGION);

  function automatic logic [REGION_W-1:0] region_of(input logic [PAGE_W-1:0] pg);
    return REGION_W'(pg / PPR);
  endfunction

  logic [KEY_W-1:0]  key_f;
  logic [CODE_W-1:0] code_f;

  always_comb begin
    key_f   = word[KEY_LSB +: KEY_W];
    page    = word[PAGE_LSB +: PAGE_W];
    code_f  = word[0 +: CODE_W];
    key_ok  = (key_f == KEY);
    op      = decode_op(code_f);
    page_ok = (page < NP_LIM);
    region  = region_of(page);
  end

endmodule

// File: rtl/flash_lock_bank.sv
module flash_lock_bank #(
  parameter int NUM_REGIONS = 8,
  parameter int REGION_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_en,
  input  logic                clr_en,
  input  logic [REGION_W-1:0] wr_region,
  input  logic [REGION_W-1:0] rd_region,
  output logic                rd_locked
);

  localparam logic [REGION_W:0] NR_LIM = (REGION_W+1)'(NUM_REGIONS);

  logic [NUM_REGIONS-1:0] lock_q;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    logic hit;
    assign hit = (wr_region == REGION_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                lock_q[g] <= 1'b0;
      else if (set_en && hit)    lock_q[g] <= 1'b1;
      else if (clr_en && hit)    lock_q[g] <= 1'b0;
    end
  end

  always_comb begin
    rd_locked = 1'b0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (rd_region == REGION_W'(i)) rd_locked = lock_q[i];
    end
    if ({1'b0, rd_region} >= NR_LIM) rd_locked = 1'b0;
  end

endmodule

// File: rtl/flash_phase_seq.sv
module flash_phase_seq
  import flash_cmd_pkg::*;
#(
  parameter int ERASE_CYCLES = 20,
  parameter int PROG_CYCLES  = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_erase,
  input  logic start_prog,
  output logic busy,
  output logic arr_erase,
  output logic arr_prog,
  output logic done_evt
);

  localparam int MAXC  = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] E_LAST = CNT_W'(ERASE_CYCLES - 1);
  localparam logic [CNT_W-1:0] P_LAST = CNT_W'(PROG_CYCLES - 1);

  phase_t           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    unique case (ph_q)
      PH_IDLE: begin
        cnt_d = '0;
        if (start) begin
          if (start_erase)     ph_d = PH_ERASE;
          else if (start_prog) ph_d = PH_PROG;
          else                 ph_d = PH_DONE;
        end
      end
      PH_ERASE: begin
        if (cnt_q == E_LAST) begin
          ph_d  = PH_PROG;
          cnt_d = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      PH_PROG: begin
        if (cnt_q == P_LAST) begin
          ph_d  = PH_DONE;
          cnt_d = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      PH_DONE: ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy      = (ph_q != PH_IDLE);
  assign arr_erase = (ph_q == PH_ERASE);
  assign arr_prog  = (ph_q == PH_PROG);
  assign done_evt  = (ph_q == PH_DONE);

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter logic [7:0] KEY              = 8'h5A,
  parameter int         NUM_PAGES        = 64,
  parameter int         PAGES_PER_REGION = 8,
  parameter int         ERASE_CYCLES     = 20,
  parameter int         PROG_CYCLES      = 30
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_we,
  input  logic [31:0] cmd_wdata,
  input  logic        mode_we,
  input  logic        mode_rdy_ie,
  input  logic        stat_re,
  output logic [7:0]  stat_rdata,
  output logic        irq,
  output logic        arr_erase,
  output logic        arr_prog,
  output logic [15:0] arr_page
);

  localparam int NUM_REGIONS = (NUM_PAGES + PAGES_PER_REGION - 1) / PAGES_PER_REGION;
  localparam int REGION_W    = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;

  // decoded fields of the incoming word
  logic                key_ok;
  op_t                 op;
  logic                page_ok;
  logic [PAGE_W-1:0]   page;
  logic [REGION_W-1:0] region;
  logic                locked;

  // named events, also watched by the checker
  logic ready_w, fmt_ok_w, accept_w, reject_fmt_w, reject_busy_w, reject_lock_w;
  logic done_evt_w;

  // latched job
  logic [PAGE_W-1:0]   job_page_q;
  logic [REGION_W-1:0] job_region_q;
  logic                job_lock_q, job_unlock_q;

  // status and mode
  logic cmd_err_q, lock_err_q, done_q, irq_en_q;
  logic busy_w;

  flash_cmd_decode #(
    .KEY(KEY), .NUM_PAGES(NUM_PAGES),
    .PAGES_PER_REGION(PAGES_PER_REGION), .REGION_W(REGION_W)
  ) u_dec (
    .word(cmd_wdata), .key_ok(key_ok), .op(op), .page_ok(page_ok),
    .page(page), .region(region)
  );

  flash_lock_bank #(.NUM_REGIONS(NUM_REGIONS), .REGION_W(REGION_W)) u_lock (
    .clk(clk), .rst_n(rst_n),
    .set_en(done_evt_w && job_lock_q),
    .clr_en(done_evt_w && job_unlock_q),
    .wr_region(job_region_q),
    .rd_region(region),
    .rd_locked(locked)
  );

  flash_phase_seq #(.ERASE_CYCLES(ERASE_CYCLES), .PROG_CYCLES(PROG_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(accept_w), .start_erase(op.erase), .start_prog(op.prog),
    .busy(busy_w), .arr_erase(arr_erase), .arr_prog(arr_prog),
    .done_evt(done_evt_w)
  );

  always_comb begin
    ready_w       = !busy_w;
    fmt_ok_w      = key_ok && op.valid && page_ok;
    reject_busy_w = cmd_we && !ready_w;
    reject_fmt_w  = cmd_we && ready_w && !fmt_ok_w;
    reject_lock_w = cmd_we && ready_w && fmt_ok_w && op.prog && locked;
    accept_w      = cmd_we && ready_w && fmt_ok_w && !(op.prog && locked);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      job_page_q   <= '0;
      job_region_q <= '0;
      job_lock_q   <= 1'b0;
      job_unlock_q <= 1'b0;
    end else if (accept_w) begin
      job_page_q   <= page;
      job_region_q <= region;
      job_lock_q   <= op.lock_after || op.set_lock;
      job_unlock_q <= op.clr_lock;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_err_q  <= 1'b0;
      lock_err_q <= 1'b0;
      done_q     <= 1'b0;
      irq_en_q   <= 1'b0;
    end else begin
      cmd_err_q  <= (cmd_err_q && !stat_re) || reject_fmt_w || reject_busy_w;
      lock_err_q <= (lock_err_q && !stat_re) || reject_lock_w;
      if (done_evt_w)                 done_q <= 1'b1;
      else if (stat_re || accept_w)   done_q <= 1'b0;
      if (mode_we) irq_en_q <= mode_rdy_ie;
    end
  end

  always_comb begin
    stat_rdata          = '0;
    stat_rdata[ST_RDY]  = ready_w;
    stat_rdata[ST_CERR] = cmd_err_q;
    stat_rdata[ST_LERR] = lock_err_q;
  end

  assign irq      = done_q && irq_en_q;
  assign arr_page = job_page_q;

endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_we,
  input logic stat_re,
  input logic ready,
  input logic cmd_err,
  input logic lock_err,
  input logic irq,
  input logic irq_en,
  input logic arr_erase,
  input logic arr_prog,
  input logic accept,
  input logic reject_lock,
  input logic done_evt
);

  AST_BUSY_CMD_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !ready) |=> cmd_err);                                   // R8
  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready);                                                // R3
  AST_DONE_RESTORES_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> ready);                                               // R3
  AST_LOCK_REJECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    reject_lock |=> (ready && !arr_prog && !arr_erase && lock_err));   // R6
  AST_PHASES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_erase && arr_prog));                                         // R4
  AST_ERASE_THEN_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(arr_erase) |-> arr_prog);                                    // R4
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en);                                                   // R10
  AST_READ_CLEARS_ERRORS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_re && !cmd_we) |=> (!cmd_err && !lock_err));                 // R9

endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .stat_re(stat_re),
  .ready(ready_w), .cmd_err(cmd_err_q), .lock_err(lock_err_q),
  .irq(irq), .irq_en(irq_en_q), .arr_erase(arr_erase), .arr_prog(arr_prog),
  .accept(accept_w), .reject_lock(reject_lock_w), .done_evt(done_evt_w)
);

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] KEY = 8'hC3;
  localparam int NP  = 32;
  localparam int PPR = 4;
  localparam int EC  = 5;
  localparam int PC  = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_we = 1'b0, mode_we = 1'b0, mode_rdy_ie = 1'b0, stat_re = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [7:0]  stat_rdata;
  logic irq, arr_erase, arr_prog;
  logic [15:0] arr_page;

  int n_chk = 0, n_bad = 0;
  bit lk [NP/PPR];
  bit ie_m = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_ctrl #(.KEY(KEY), .NUM_PAGES(NP), .PAGES_PER_REGION(PPR),
                   .ERASE_CYCLES(EC), .PROG_CYCLES(PC)) i_flash_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .mode_we(mode_we), .mode_rdy_ie(mode_rdy_ie), .stat_re(stat_re),
    .stat_rdata(stat_rdata), .irq(irq), .arr_erase(arr_erase),
    .arr_prog(arr_prog), .arr_page(arr_page));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit code_ok(input logic [7:0] c);
    return (c >= 8'h01 && c <= 8'h04) || c == 8'h08 || c == 8'h09;
  endfunction
  function automatic bit is_prog(input logic [7:0] c);
    return c >= 8'h01 && c <= 8'h04;
  endfunction
  function automatic bit has_erase(input logic [7:0] c);
    return c == 8'h03 || c == 8'h04;
  endfunction
  function automatic int exp_busy(input logic [7:0] c);
    if (!is_prog(c)) return 1;
    return (has_erase(c) ? EC : 0) + PC + 1;
  endfunction
  function automatic int reg_of(input int pg);
    return pg / PPR;
  endfunction

  task automatic set_ie(input bit b);
    @(negedge clk); mode_we = 1'b1; mode_rdy_ie = b;
    @(negedge clk); mode_we = 1'b0;
    ie_m = b;
  endtask

  // issue a command; optionally a second write while busy (R8)
  task automatic do_cmd(input logic [7:0] key, input int page, input logic [7:0] code,
                        input bit poke_busy);
    bit fmt, lrej, acc;
    int busy, ne, np_, guard;
    fmt  = (key == KEY) && code_ok(code) && (page < NP);
    lrej = fmt && is_prog(code) && lk[reg_of(page)];
    acc  = fmt && !lrej;
    @(negedge clk);
    cmd_we = 1'b1; cmd_wdata = {key, 16'(page), code};
    @(negedge clk);
    busy = 0; ne = 0; np_ = 0; guard = 0;
    if (poke_busy && acc) begin
      cmd_wdata = {KEY, 16'(page ^ 1), 8'h01};
      busy = 1; np_ = int'(arr_prog); ne = int'(arr_erase);
      @(negedge clk);
    end
    cmd_we = 1'b0;
    while (stat_rdata[0] == 1'b0 && guard < 1000) begin
      busy++; ne += int'(arr_erase); np_ += int'(arr_prog); guard++;
      @(negedge clk);
    end
    chk("R3 busy cycles", busy, acc ? exp_busy(code) : 0);
    chk("R4 erase cycles", ne, (acc && has_erase(code)) ? EC : 0);
    chk("R4 program cycles", np_, (acc && is_prog(code)) ? PC : 0);
    chk("R10 irq after completion", int'(irq), int'(acc && ie_m));
    if (poke_busy && acc) chk("R8 busy write flagged", int'(stat_rdata[1]), 1);
    else if (key != KEY) chk("R1 bad key flagged", int'(stat_rdata[1]), 1);
    else chk("R2 command error flag", int'(stat_rdata[1]), int'(!fmt));
    chk("R6 lock error flag", int'(stat_rdata[2]), int'(lrej));
    stat_re = 1'b1;
    @(negedge clk);
    stat_re = 1'b0;
    chk("R9 errors cleared by read", int'(stat_rdata[2:1]), 0);
    chk("R10 irq cleared by read", int'(irq), 0);
    if (acc && (code == 8'h02 || code == 8'h04 || code == 8'h08)) lk[reg_of(page)] = 1'b1;
    if (acc && code == 8'h09) lk[reg_of(page)] = 1'b0;
  endtask

  initial begin
    logic [7:0] codes [9] = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h08, 8'h09,
                             8'h00, 8'h05, 8'h0F};
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < NP/PPR; i++) lk[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 status after reset", int'(stat_rdata), 1);
    chk("R11 irq after reset", int'(irq), 0);
    chk("R11 strobes idle", int'({arr_erase, arr_prog}), 0);

    // R1, R2 directed rejects
    do_cmd(KEY ^ 8'h01, 3, 8'h01, 1'b0);
    do_cmd(KEY, 3, 8'h07, 1'b0);
    do_cmd(KEY, NP, 8'h01, 1'b0);
    // R3/R4 plain and erase variants, R10 with interrupt on
    set_ie(1'b1);
    do_cmd(KEY, 0, 8'h01, 1'b0);
    do_cmd(KEY, NP-1, 8'h03, 1'b0);
    // R8 write during busy
    do_cmd(KEY, 12, 8'h03, 1'b1);
    // R5 write+lock on page 5 locks region 1 (pages 4..7)
    do_cmd(KEY, 5, 8'h02, 1'b0);
    do_cmd(KEY, 7, 8'h01, 1'b0);   // R6 expect lock error
    do_cmd(KEY, 4, 8'h03, 1'b0);   // R6 erase variant blocked too
    do_cmd(KEY, 8, 8'h01, 1'b0);   // R7 next region unaffected
    set_ie(1'b0);
    do_cmd(KEY, 6, 8'h09, 1'b0);   // R7 unlock region 1
    do_cmd(KEY, 4, 8'h04, 1'b0);   // R5 erase+write+lock
    do_cmd(KEY, 5, 8'h01, 1'b0);   // R6
    do_cmd(KEY, 20, 8'h08, 1'b0);  // R7 explicit lock region 5
    do_cmd(KEY, 23, 8'h03, 1'b0);  // R6
    do_cmd(KEY, 24, 8'h03, 1'b0);  // R7 boundary

    // random mix
    for (int it = 0; it < 220; it++) begin
      logic [7:0] k, c;
      int pg;
      if (it % 16 == 0) set_ie(1'($urandom % 2));
      k  = ($urandom % 8 == 0) ? (KEY ^ 8'(1 + $urandom % 255)) : KEY;
      c  = codes[$urandom % 9];
      if ($urandom % 4 == 0) c = 8'h09;
      pg = int'($urandom % (NP + 4));
      do_cmd(k, pg, c, ($urandom % 10) == 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R3 watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule